// File: doc/BRIEF.md
# Instruction Fetch Permission Gate

This block decides, once per clock, whether instruction-type bus accesses to an on-chip SRAM may proceed. It keeps a 4-bit execute-enable register and a one-bit lock register, both reachable through a small synchronous write port and a combinational read port. It produces a single registered permit bit by combining that register with an 8-bit fuse-derived setting and a 4-bit life-cycle debug-enable input.

All three controls are multibit-encoded. Only the exact true pattern of each counts as true. Every other pattern, including a true pattern with one bit flipped, counts as false. When the fuse setting is true, software decides through the execute-enable register. When the fuse setting is anything else, the life-cycle debug-enable input decides on its own. A build-time parameter can remove execution support, and then the permit bit stays low.

Top module: `exec_fetch_gate`

## Requirements
- R1: Reset leaves the permit output at 0, the lock register at 1, and the execute-enable register at the false pattern 4'h9.
- R2: The lock register sits at address 0, bit 0. A write of 0 to bit 0 clears it. A write of 1 has no effect. Once cleared, it stays 0 until reset. Reading address 0 returns {3'b000, lock}.
- R3: The execute-enable register sits at address 1, bits 3:0. While the lock is 1, a write stores all four bits. While the lock is 0, writes are ignored. Reading address 1 returns the stored value.
- R4: When the fuse input equals 8'h96, the permit is 1 exactly when the execute-enable register holds 4'h6.
- R5: When the fuse input is not 8'h96, the permit is 1 exactly when the debug-enable input equals 4'h6, whatever the register holds.
- R6: The permit is a register. It reflects the inputs and register contents present before the previous rising edge, so a write becomes visible at the output one cycle after it is stored.
- R7: With the execution-support parameter set to 0, the permit is always 0.
- R8: Any value other than the exact true pattern counts as false. This includes every single-bit corruption of 4'h6 and 8'h96.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 lock, 1 execute-enable |
| wr_data | input | 4 | Write data |
| rd_addr | input | 1 | Read target: 0 lock, 1 execute-enable |
| rd_data | output | 4 | Read data for rd_addr |
| fuse_exec | input | 8 | Multibit fuse setting for execution |
| dbg_en | input | 4 | Multibit life-cycle debug enable |
| fetch_ok | output | 1 | Registered permit for instruction fetches |

## Verification
The bench feeds each control every single-bit corruption of its true pattern. A gate that decodes by a single bit or a majority vote would then grant fetches it must refuse. The bench writes 1 to a cleared lock and then attempts enable writes. A lock that reopens, or that lacks write gating, would let the register change. Toggling the fuse while the register and debug inputs disagree catches a gate that ORs both paths instead of selecting one of them. Sampling exactly one cycle after each change exposes any extra or missing output stage.

// File: rtl/exec_fetch_gate.sv
module exec_fetch_gate #(
  parameter bit       ExecSupport = 1'b1,
  parameter int       EnW         = 4,
  parameter int       FuseW       = 8,
  parameter logic [3:0] EnTrue    = 4'h6,
  parameter logic [3:0] EnFalse   = 4'h9,
  parameter logic [7:0] FuseTrue  = 8'h96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [EnW-1:0]   wr_data,
  input  logic             rd_addr,
  output logic [EnW-1:0]   rd_data,
  input  logic [FuseW-1:0] fuse_exec,
  input  logic [EnW-1:0]   dbg_en,
  output logic             fetch_ok
);
  localparam logic AddrLock = 1'b0;
  localparam logic AddrEn   = 1'b1;

  logic           lock_q;
  logic [EnW-1:0] en_q;
  logic           fuse_on, reg_on, dbg_on, permit_d;

  assign fuse_on  = (fuse_exec == FuseTrue);
  assign reg_on   = (en_q == EnTrue);
  assign dbg_on   = (dbg_en == EnTrue);
  assign permit_d = ExecSupport && (fuse_on ? reg_on : dbg_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b1;
      en_q     <= EnFalse;
      fetch_ok <= 1'b0;
    end else begin
      fetch_ok <= permit_d;
      if (wr_en && wr_addr == AddrLock && !wr_data[0]) lock_q <= 1'b0;
      if (wr_en && wr_addr == AddrEn && lock_q) en_q <= wr_data;
    end
  end

  assign rd_data = (rd_addr == AddrEn) ? en_q : {{(EnW-1){1'b0}}, lock_q};

  assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> !lock_q);

  assert_en_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> $stable(en_q));

  assert_fuse_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_exec == FuseTrue && en_q != EnTrue) |=> !fetch_ok);

  assert_dbg_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_exec != FuseTrue && dbg_en != EnTrue) |=> !fetch_ok);

  assert_no_support_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ExecSupport |-> !fetch_ok);
endmodule

// File: tb/sim_exec_fetch_gate.sv
module sim_exec_fetch_gate;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, wr_addr = 0, rd_addr = 0;
  logic [3:0] wr_data = 0, dbg_en = 0, rd_data, rd_data1;
  logic [7:0] fuse_exec = 0;
  logic       fetch_ok, fetch_ok1;
  int total = 0, bad = 0;
  logic       m_lock;
  logic [3:0] m_en;

  always #2 clk = ~clk;

  exec_fetch_gate u0 (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr,
    .rd_data, .fuse_exec, .dbg_en, .fetch_ok);
  exec_fetch_gate #(.ExecSupport(1'b0)) u1 (.clk, .rst_n, .wr_en, .wr_addr,
    .wr_data, .rd_addr, .rd_data(rd_data1), .fuse_exec, .dbg_en,
    .fetch_ok(fetch_ok1));

  function automatic logic exp_permit(logic [3:0] en, logic [7:0] f, logic [3:0] d);
    return (f == 8'h96) ? (en == 4'h6) : (d == 4'h6);
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic we, logic wa, logic [3:0] wd, logic ra,
                      logic [7:0] f, logic [3:0] d, string tag);
    logic e;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    fuse_exec = f; dbg_en = d;
    e = exp_permit(m_en, f, d);
    if (we && !wa && !wd[0]) m_lock = 0;
    if (we && wa && m_lock) m_en = wd;
    @(posedge clk); @(negedge clk);
    chk({tag, " R6 permit"}, {3'b0, fetch_ok}, {3'b0, e});
    chk({tag, " R2/R3 readback"}, rd_data, ra ? m_en : {3'b0, m_lock});
    chk("R7 no support", {3'b0, fetch_ok1}, 4'h0);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog R6 actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_lock = 1; m_en = 4'h9;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_addr = 0; #0;
    chk("R1 permit", {3'b0, fetch_ok}, 4'h0);
    chk("R1 lock", rd_data, 4'h1);
    rd_addr = 1; #1;
    chk("R1 enable", rd_data, 4'h9);
    // R4: enable via register with fuse true
    step(1, 1, 4'h6, 1, 8'h96, 4'h0, "R4 write");
    step(0, 0, 0, 1, 8'h96, 4'h0, "R4 on");
    step(0, 0, 0, 1, 8'h00, 4'h0, "R5 fuse off");
    step(0, 0, 0, 1, 8'h00, 4'h6, "R5 dbg on");
    // R8: corrupted patterns
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 8'h96 ^ (8'h1 << i), 4'h0, "R8 fuse flip");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 8'h00, 4'h6 ^ (4'h1 << i), "R8 dbg flip");
    for (int i = 0; i < 4; i++) step(1, 1, 4'h6 ^ (4'h1 << i), 1, 8'h96, 4'h6, "R8 en flip");
    // R2/R3: lock behaviour
    step(1, 0, 4'h1, 0, 8'h96, 4'h0, "R2 write one");
    step(1, 1, 4'h6, 1, 8'h96, 4'h0, "R3 open write");
    step(1, 0, 4'h0, 0, 8'h96, 4'h0, "R2 clear");
    step(1, 0, 4'h1, 0, 8'h96, 4'h0, "R2 no reopen");
    step(1, 1, 4'h9, 1, 8'h96, 4'h0, "R3 locked write");
    step(0, 0, 0, 1, 8'h96, 4'h0, "R3 still on");
    // random phase with a fresh reset
    rst_n = 0; m_lock = 1; m_en = 4'h9;
    @(negedge clk); rst_n = 1;
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] f;
      logic [3:0] d, wd;
      int r;
      r = $urandom % 4;
      f = (r == 0) ? 8'($urandom) : (r == 1) ? (8'h96 ^ (8'h1 << ($urandom % 8))) : 8'h96;
      if ($urandom % 2) f = 8'h96;
      d = ($urandom % 2) ? 4'h6 : 4'($urandom);
      wd = ($urandom % 2) ? 4'h6 : 4'($urandom);
      if (n < 2500 && !wd[0] && ($urandom % 40 != 0)) wd[0] = 1'b1;
      step(1'($urandom % 3 == 0), 1'($urandom % 4 != 0), wd, 1'($urandom),
           f, d, "R4/R5 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule